// File: doc/BRIEF.md
# Operand Bypass and Hazard Control

This block is the combinational hazard controller of a five-stage in-order core (fetch, decode, execute, memory, writeback). Each cycle it takes the source register indices of the instruction in decode. It compares them with the destinations of the instructions still in flight in the execute, memory and writeback stages, and picks one bypass source for each register read port. The candidates are the register file, the execute-stage result register T, the memory-stage copy T1, the load data register, or the writeback value.

An ALU result or a link address can be handed on as soon as execute has produced it. A load value only exists once the memory access is done. A load that is followed at once by a consumer therefore holds fetch and decode for one cycle and sends a bubble into execute. Jumps resolve in execute. A taken jump squashes the two younger instructions, unless the block is built in delayed-branch mode, where those instructions complete.

Top module: `fwd_unit`

## Requirements
- R1: Each read port has its own 3-bit select, computed from that port's source index alone. The encodings are 0 = register file, 1 = execute result T, 2 = memory-stage T1, 3 = memory-stage load data, 4 = writeback value.
- R2: A valid, writing execute-stage instruction whose class is not load (class encoding: 0 ALU, 1 load, 2 link, 3 other) and whose destination equals a used source makes that port select 1. Link results are included.
- R3: A matching valid, writing memory-stage instruction gives select 2 when its class is not load, and select 3 when its class is load (1).
- R4: A matching valid, writing writeback-stage instruction gives select 4.
- R5: When several stages match, the youngest wins: execute over memory over writeback.
- R6: A stage with its valid or write enable low never matches. A port whose use bit is low selects 0.
- R7: A used source that matches a valid, writing execute-stage load raises stall, and that port selects 0 while the stall lasts.
- R8: Register index 0 is forwarded exactly like any other index.
- R9: With DELAYED_BRANCH = 0, a taken jump raises flush and forces stall low.
- R10: With DELAYED_BRANCH = 1, flush stays low whatever the jump input does, and stall is unaffected by the jump.
- R11: stall is low whenever the decode-stage valid bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | 1 | Decode stage holds a real instruction |
| src_idx | input | NUM_RD*IDX_W | Source register index per read port |
| src_use | input | NUM_RD | Read port actually needed by the decode instruction |
| ex_valid | input | 1 | Execute stage valid |
| ex_wen | input | 1 | Execute stage writes a register |
| ex_dst | input | IDX_W | Execute stage destination index |
| ex_cls | input | 2 | Execute stage instruction class |
| mem_valid | input | 1 | Memory stage valid |
| mem_wen | input | 1 | Memory stage writes a register |
| mem_dst | input | IDX_W | Memory stage destination index |
| mem_cls | input | 2 | Memory stage instruction class |
| wb_valid | input | 1 | Writeback stage valid |
| wb_wen | input | 1 | Writeback stage writes a register |
| wb_dst | input | IDX_W | Writeback stage destination index |
| jump_taken | input | 1 | Jump in execute is taken this cycle |
| fwd_sel | output | NUM_RD*3 | Bypass select per read port |
| stall | output | 1 | Hold fetch and decode, insert a bubble into execute |
| flush | output | 1 | Squash fetch and decode |

## Verification
Every output is a pure function of the current inputs, so each select, stall and flush is due in the same cycle as the stimulus that causes it, with no register on the path. The bench changes inputs just after a rising clock edge and samples the outputs at the next falling edge, half a period later, which is long enough for the values to settle. A second instance built in delayed-branch mode receives the same inputs, so the jump behaviour of both variants is compared in the same cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      CLS_ALU   = 2'd0,
      CLS_LOAD  = 2'd1,
      CLS_LINK  = 2'd2,
      CLS_OTHER = 2'd3
   } icls_e;

   typedef enum logic [2:0] {
      SEL_RF     = 3'd0,
      SEL_EX_T   = 3'd1,
      SEL_MEM_T1 = 3'd2,
      SEL_MEM_LD = 3'd3,
      SEL_WB     = 3'd4
   } fsel_e;

   localparam int SEL_W   = 3;
   localparam int NUM_STG = 3;
   localparam int STG_EX  = 0;
   localparam int STG_MEM = 1;
   localparam int STG_WB  = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int IDX_W  = 5,
   parameter int NUM_RD = 2
) (
   input  logic [NUM_RD-1:0][IDX_W-1:0] src_idx,
   input  logic [NUM_RD-1:0]            src_use,
   input  logic                         st_valid,
   input  logic                         st_wen,
   input  logic [IDX_W-1:0]             st_dst,
   output logic [NUM_RD-1:0]            hit
);

   logic producing;
   assign producing = st_valid & st_wen;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      assign hit[p] = producing & src_use[p] & (src_idx[p] == st_dst);
   end

endmodule

// File: rtl/fwd_port_sel.sv
module fwd_port_sel
   import fwd_pkg::*;
(
   input  logic             hit_ex,
   input  logic             hit_mem,
   input  logic             hit_wb,
   input  logic             ex_is_load,
   input  logic             mem_is_load,
   output logic [SEL_W-1:0] sel,
   output logic             ld_wait
);

   assign ld_wait = hit_ex & ex_is_load;

   always_comb begin
      if (hit_ex) begin
         sel = ex_is_load ? SEL_RF : SEL_EX_T;
      end else if (hit_mem) begin
         sel = mem_is_load ? SEL_MEM_LD : SEL_MEM_T1;
      end else if (hit_wb) begin
         sel = SEL_WB;
      end else begin
         sel = SEL_RF;
      end
   end

endmodule

// File: rtl/fwd_hazard.sv
module fwd_hazard #(
   parameter int NUM_RD         = 2,
   parameter bit DELAYED_BRANCH = 1'b0
) (
   input  logic [NUM_RD-1:0] ld_wait,
   input  logic              dec_valid,
   input  logic              jump_taken,
   output logic              stall,
   output logic              flush
);

   logic need_wait;
   assign need_wait = dec_valid & (|ld_wait);

   if (DELAYED_BRANCH) begin : g_delayed
      logic unused_jump;
      assign unused_jump = jump_taken;
      assign flush = 1'b0;
      assign stall = need_wait;
   end else begin : g_squash
      assign flush = jump_taken;
      assign stall = need_wait & ~jump_taken;
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int IDX_W          = 5,
   parameter int NUM_RD         = 2,
   parameter bit DELAYED_BRANCH = 1'b0
) (
   input  logic                          dec_valid,
   input  logic [NUM_RD-1:0][IDX_W-1:0]  src_idx,
   input  logic [NUM_RD-1:0]             src_use,
   input  logic                          ex_valid,
   input  logic                          ex_wen,
   input  logic [IDX_W-1:0]              ex_dst,
   input  logic [1:0]                    ex_cls,
   input  logic                          mem_valid,
   input  logic                          mem_wen,
   input  logic [IDX_W-1:0]              mem_dst,
   input  logic [1:0]                    mem_cls,
   input  logic                          wb_valid,
   input  logic                          wb_wen,
   input  logic [IDX_W-1:0]              wb_dst,
   input  logic                          jump_taken,
   output logic [NUM_RD-1:0][SEL_W-1:0]  fwd_sel,
   output logic                          stall,
   output logic                          flush
);

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("fwd_unit: IDX_W must lie in 1..8");
   end
   if (NUM_RD < 1 || NUM_RD > 4) begin : g_bad_rd
      $error("fwd_unit: NUM_RD must lie in 1..4");
   end

   logic [NUM_STG-1:0]              stg_valid;
   logic [NUM_STG-1:0]              stg_wen;
   logic [NUM_STG-1:0][IDX_W-1:0]   stg_dst;
   logic [NUM_STG-1:0][NUM_RD-1:0]  stg_hit;
   logic [NUM_RD-1:0]               ld_wait;
   logic                            ex_is_load;
   logic                            mem_is_load;

   assign stg_valid = {wb_valid, mem_valid, ex_valid};
   assign stg_wen   = {wb_wen,   mem_wen,   ex_wen};
   assign stg_dst   = {wb_dst,   mem_dst,   ex_dst};

   assign ex_is_load  = (ex_cls  == CLS_LOAD);
   assign mem_is_load = (mem_cls == CLS_LOAD);

   for (genvar s = 0; s < NUM_STG; s++) begin : g_stage
      fwd_match #(
         .IDX_W  (IDX_W),
         .NUM_RD (NUM_RD)
      ) u_match (
         .src_idx  (src_idx),
         .src_use  (src_use),
         .st_valid (stg_valid[s]),
         .st_wen   (stg_wen[s]),
         .st_dst   (stg_dst[s]),
         .hit      (stg_hit[s])
      );
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_port
      fwd_port_sel u_sel (
         .hit_ex      (stg_hit[STG_EX][p]),
         .hit_mem     (stg_hit[STG_MEM][p]),
         .hit_wb      (stg_hit[STG_WB][p]),
         .ex_is_load  (ex_is_load),
         .mem_is_load (mem_is_load),
         .sel         (fwd_sel[p]),
         .ld_wait     (ld_wait[p])
      );
   end

   fwd_hazard #(
      .NUM_RD         (NUM_RD),
      .DELAYED_BRANCH (DELAYED_BRANCH)
   ) u_hazard (
      .ld_wait    (ld_wait),
      .dec_valid  (dec_valid),
      .jump_taken (jump_taken),
      .stall      (stall),
      .flush      (flush)
   );

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
   import fwd_pkg::*;
#(
   parameter int IDX_W          = 5,
   parameter int NUM_RD         = 2,
   parameter bit DELAYED_BRANCH = 1'b0
) (
   input logic                          dec_valid,
   input logic [NUM_RD-1:0][IDX_W-1:0]  src_idx,
   input logic [NUM_RD-1:0]             src_use,
   input logic                          ex_valid,
   input logic                          ex_wen,
   input logic [IDX_W-1:0]              ex_dst,
   input logic [1:0]                    ex_cls,
   input logic                          mem_valid,
   input logic                          mem_wen,
   input logic [IDX_W-1:0]              mem_dst,
   input logic                          wb_valid,
   input logic                          wb_wen,
   input logic [IDX_W-1:0]              wb_dst,
   input logic                          jump_taken,
   input logic [NUM_RD-1:0][SEL_W-1:0]  fwd_sel,
   input logic                          stall,
   input logic                          flush
);

   always_comb begin
      logic any_ld;
      any_ld = 1'b0;
      for (int p = 0; p < NUM_RD; p++) begin
         if (src_use[p] && ex_valid && ex_wen && ex_dst == src_idx[p] && ex_cls == CLS_LOAD)
            any_ld = 1'b1;
         p_unused_rf_r6: assert (src_use[p] || fwd_sel[p] == SEL_RF)
            else $error("unused port selects a bypass");
         p_ex_src_ok_r2: assert (fwd_sel[p] != SEL_EX_T ||
                                 (ex_valid && ex_wen && ex_dst == src_idx[p] && ex_cls != CLS_LOAD))
            else $error("execute bypass without a producer");
         p_mem_src_ok_r3: assert (!(fwd_sel[p] == SEL_MEM_T1 || fwd_sel[p] == SEL_MEM_LD) ||
                                  (mem_valid && mem_wen && mem_dst == src_idx[p]))
            else $error("memory bypass without a producer");
         p_wb_src_ok_r4: assert (fwd_sel[p] != SEL_WB ||
                                 (wb_valid && wb_wen && wb_dst == src_idx[p]))
            else $error("writeback bypass without a producer");
         p_sel_range_r1: assert (fwd_sel[p] <= SEL_WB)
            else $error("select out of range");
      end
      p_stall_cause_r7: assert (!stall || (any_ld && dec_valid))
         else $error("stall without a pending load");
      p_no_dec_stall_r11: assert (dec_valid || !stall)
         else $error("stall while decode empty");
      p_flush_excl_r9: assert (!(flush && stall))
         else $error("flush and stall together");
      p_no_flush_r10: assert (!DELAYED_BRANCH || !flush)
         else $error("flush in delayed-branch mode");
      p_flush_jump_r9: assert (DELAYED_BRANCH || flush == jump_taken)
         else $error("flush does not follow taken jump");
   end

endmodule

bind fwd_unit fwd_unit_chk #(
   .IDX_W          (IDX_W),
   .NUM_RD         (NUM_RD),
   .DELAYED_BRANCH (DELAYED_BRANCH)
) u_chk (
   .dec_valid  (dec_valid),
   .src_idx    (src_idx),
   .src_use    (src_use),
   .ex_valid   (ex_valid),
   .ex_wen     (ex_wen),
   .ex_dst     (ex_dst),
   .ex_cls     (ex_cls),
   .mem_valid  (mem_valid),
   .mem_wen    (mem_wen),
   .mem_dst    (mem_dst),
   .wb_valid   (wb_valid),
   .wb_wen     (wb_wen),
   .wb_dst     (wb_dst),
   .jump_taken (jump_taken),
   .fwd_sel    (fwd_sel),
   .stall      (stall),
   .flush      (flush)
);

// File: tb/tb_fwd_unit.sv
`timescale 1ns/1ps
module tb_fwd_unit;

   localparam int IDX_W = 5;
   localparam int NRD   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                       dec_valid;
   logic [NRD-1:0][IDX_W-1:0]  src_idx;
   logic [NRD-1:0]             src_use;
   logic                       ex_valid, ex_wen, mem_valid, mem_wen, wb_valid, wb_wen;
   logic [IDX_W-1:0]           ex_dst, mem_dst, wb_dst;
   logic [1:0]                 ex_cls, mem_cls;
   logic                       jump_taken;
   logic [NRD-1:0][2:0]        sel_a, sel_b;
   logic                       stall_a, flush_a, stall_b, flush_b;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   fwd_unit #(.IDX_W(IDX_W), .NUM_RD(NRD), .DELAYED_BRANCH(1'b0)) dut (
      .dec_valid(dec_valid), .src_idx(src_idx), .src_use(src_use),
      .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_cls(ex_cls),
      .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_cls(mem_cls),
      .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dst(wb_dst),
      .jump_taken(jump_taken), .fwd_sel(sel_a), .stall(stall_a), .flush(flush_a));

   fwd_unit #(.IDX_W(IDX_W), .NUM_RD(NRD), .DELAYED_BRANCH(1'b1)) dut_db (
      .dec_valid(dec_valid), .src_idx(src_idx), .src_use(src_use),
      .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_dst(ex_dst), .ex_cls(ex_cls),
      .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_cls(mem_cls),
      .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dst(wb_dst),
      .jump_taken(jump_taken), .fwd_sel(sel_b), .stall(stall_b), .flush(flush_b));

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      dec_valid = 1'b1; src_idx = '0; src_use = '0;
      ex_valid = 0; ex_wen = 0; ex_dst = '0; ex_cls = 2'd0;
      mem_valid = 0; mem_wen = 0; mem_dst = '0; mem_cls = 2'd0;
      wb_valid = 0; wb_wen = 0; wb_dst = '0; jump_taken = 0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic next();
      @(posedge clk);
      #0.5;
   endtask

   task automatic t_idle();
      next(); idle(); settle();
      check("R6 idle port0 sel", sel_a[0], 0);
      check("R6 idle port1 sel", sel_a[1], 0);
      check("R6 idle stall", stall_a, 0);
      check("R9 idle flush", flush_a, 0);
   endtask

   task automatic t_ex_bypass();
      next(); idle();
      src_idx[0] = 5'd5; src_idx[1] = 5'd7; src_use = 2'b11;
      ex_valid = 1; ex_wen = 1; ex_dst = 5'd5; ex_cls = 2'd0;
      settle();
      check("R2 ex alu port0", sel_a[0], 1);
      check("R1 other port untouched", sel_a[1], 0);
      next(); ex_cls = 2'd2; ex_dst = 5'd7; settle();
      check("R2 ex link port1", sel_a[1], 1);
      check("R1 port0 now rf", sel_a[0], 0);
   endtask

   task automatic t_mem_bypass();
      next(); idle();
      src_idx[1] = 5'd3; src_use = 2'b10;
      mem_valid = 1; mem_wen = 1; mem_dst = 5'd3; mem_cls = 2'd0;
      settle();
      check("R3 mem t1", sel_a[1], 2);
      next(); mem_cls = 2'd1; settle();
      check("R3 mem load data", sel_a[1], 3);
      check("R3 mem load no stall", stall_a, 0);
   endtask

   task automatic t_wb_bypass();
      next(); idle();
      src_idx[0] = 5'd12; src_idx[1] = 5'd12; src_use = 2'b11;
      wb_valid = 1; wb_wen = 1; wb_dst = 5'd12;
      settle();
      check("R4 wb port0", sel_a[0], 4);
      check("R4 wb port1", sel_a[1], 4);
   endtask

   task automatic t_priority();
      next(); idle();
      src_idx[0] = 5'd9; src_use = 2'b01;
      ex_valid = 1; ex_wen = 1; ex_dst = 5'd9;
      mem_valid = 1; mem_wen = 1; mem_dst = 5'd9;
      wb_valid = 1; wb_wen = 1; wb_dst = 5'd9;
      settle();
      check("R5 ex beats mem and wb", sel_a[0], 1);
      next(); ex_valid = 0; settle();
      check("R6 invalid ex skipped, R5 mem wins", sel_a[0], 2);
      next(); mem_wen = 0; settle();
      check("R6 non-writing mem skipped", sel_a[0], 4);
      next(); src_use = 2'b00; settle();
      check("R6 unused port", sel_a[0], 0);
   endtask

   task automatic t_load_use();
      next(); idle();
      src_idx[1] = 5'd4; src_use = 2'b10;
      ex_valid = 1; ex_wen = 1; ex_dst = 5'd4; ex_cls = 2'd1;
      mem_valid = 1; mem_wen = 1; mem_dst = 5'd4;
      settle();
      check("R7 load-use stall", stall_a, 1);
      check("R7 port sel rf during stall", sel_a[1], 0);
      next(); src_use = 2'b00; settle();
      check("R6 unused source no stall", stall_a, 0);
      next(); src_use = 2'b10; dec_valid = 0; settle();
      check("R11 empty decode no stall", stall_a, 0);
   endtask

   task automatic t_zero_index();
      next(); idle();
      src_idx[0] = 5'd0; src_use = 2'b01;
      mem_valid = 1; mem_wen = 1; mem_dst = 5'd0;
      settle();
      check("R8 index 0 forwarded", sel_a[0], 2);
   endtask

   task automatic t_jump();
      next(); idle();
      src_idx[0] = 5'd6; src_use = 2'b01;
      ex_valid = 1; ex_wen = 1; ex_dst = 5'd6; ex_cls = 2'd1;
      jump_taken = 1;
      settle();
      check("R9 taken jump flush", flush_a, 1);
      check("R9 flush masks stall", stall_a, 0);
      check("R10 delayed mode no flush", flush_b, 0);
      check("R10 delayed mode stall kept", stall_b, 1);
      next(); jump_taken = 0; ex_cls = 2'd0; settle();
      check("R9 no jump no flush", flush_a, 0);
      check("R10 delayed mode same select", sel_b[0], 1);
   endtask

   initial begin
      idle();
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_ex_bypass();
      t_mem_bypass();
      t_wb_bypass();
      t_priority();
      t_load_use();
      t_zero_index();
      t_jump();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule